// File: doc/BRIEF.md
# Two-Bank Output Register Demultiplexer

This block belongs to a field-bus slave. Each master call carries two payload bits and two control bits. The block routes the payload into one of two output banks, each two bits wide, that together make up the slave's four data outputs. One control bit picks the target bank. The other bit carries the A/B identity of the addressed slave. A call changes state only when that identity bit matches the identity strapped on this slave.

A mode input selects one of two behaviours. In direct mode a call writes its bank on the same clock edge. In paired mode, a call aimed at the low bank goes only into a shadow register and touches no output. A call aimed at the high bank then writes the high bank from its own payload and, on the same edge, copies the shadow register into the low bank. Both banks therefore change together. The block also emits a one-cycle pulse whenever the bank select of an accepted call differs from that of the previous accepted call. A supervising watchdog uses this pulse to see that both banks are being refreshed.

Top module: `bank_demux`

## Requirements
- R1: Call bit layout: bits [1:0] are payload, bit 2 is bank select, bit 3 is the A/B identity. In direct mode (`paired_i`=0), an accepted call with select 0 loads payload bit 0 into `data_o[2]` and bit 1 into `data_o[3]` on the edge where it is sampled. `data_o[1:0]` keeps its value.
- R2: In direct mode, an accepted call with select 1 loads payload bit 0 into `data_o[0]` and bit 1 into `data_o[1]`. `data_o[3:2]` keeps its value.
- R3: In paired mode (`paired_i`=1), an accepted call with select 1 writes its payload only into the shadow register. All four outputs keep their values.
- R4: In paired mode, an accepted call with select 0 loads its payload into `data_o[3:2]` and, on the same edge, loads the shadow register into `data_o[1:0]`.
- R5: A call is accepted only on a clock edge where `call_valid_i` is 1, `disable_i` is 0 and call bit 3 equals `slave_id_i`. Any other call changes neither the outputs nor the shadow register.
- R6: The asynchronous reset (`rst_n`=0) and a synchronous `disable_i`=1 force all four outputs and the shadow register to 0.
- R7: The cycle after an accepted call, `sel_toggle_o` is 1 for exactly one cycle if that call's select differs from the select of the previous accepted call. It is 0 otherwise. The first accepted call after reset or disable has no predecessor and gives no pulse.
- R8: A later paired-mode select-1 call overwrites the shadow register. A commit leaves the shadow register unchanged, so a second commit with no new staging loads the same low-bank value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| disable_i | input | 1 | Synchronous data-exchange disable; clears outputs and shadow |
| call_valid_i | input | 1 | One-cycle strobe marking a decoded master call |
| call_bits_i | input | 4 | Call bits: payload [1:0], bank select [2], A/B identity [3] |
| paired_i | input | 1 | 0 = direct mode, 1 = paired (staged) mode |
| slave_id_i | input | 1 | A/B identity of this slave, compared with call bit 3 |
| data_o | output | 4 | Data output registers D0..D3 |
| sel_toggle_o | output | 1 | One-cycle pulse on a change of bank select between accepted calls |

## Verification
The bench builds the block with its default bank width of two bits, which gives the four-bit call and the four outputs that the requirements describe. With that width, every payload value can be sent to both banks in both modes. Within a few cycles the bench can stage twice before one commit, commit twice from one stage, send calls to the other identity and raise disable in the middle of a staged sequence. Over those same calls the bench follows the select history, so it can predict when the toggle pulse appears, including after a disable has cleared that history.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

  // Action decoded from one call, applied by the bank registers
  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_LOW    = 3'd1,  // direct write of the low bank
    ACT_HIGH   = 3'd2,  // direct write of the high bank
    ACT_STAGE  = 3'd3,  // paired mode: payload into shadow only
    ACT_COMMIT = 3'd4   // paired mode: high from payload, low from shadow
  } bdm_act_e;

  localparam int unsigned BDM_NUM_BANKS = 2;

endpackage

// File: rtl/bdm_call_decode.sv
module bdm_call_decode
  import bdm_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  localparam int unsigned CALL_W = BANK_W + 2,
  localparam int unsigned SEL_POS = BANK_W,
  localparam int unsigned ID_POS = BANK_W + 1
) (
  input  logic              call_valid_i,
  input  logic [CALL_W-1:0] call_bits_i,
  input  logic              paired_i,
  input  logic              slave_id_i,
  input  logic              clear_i,
  output bdm_act_e          act_o,
  output logic [BANK_W-1:0] payload_o,
  output logic              sel_o,
  output logic              accept_o
);

  logic id_match;

  always_comb begin
    id_match  = (call_bits_i[ID_POS] == slave_id_i);
    accept_o  = call_valid_i && !clear_i && id_match;
    payload_o = call_bits_i[BANK_W-1:0];
    sel_o     = call_bits_i[SEL_POS];
    act_o     = ACT_NONE;
    if (accept_o) begin
      unique case ({paired_i, sel_o})
        2'b00:   act_o = ACT_HIGH;
        2'b01:   act_o = ACT_LOW;
        2'b10:   act_o = ACT_COMMIT;
        default: act_o = ACT_STAGE;
      endcase
    end
  end

  // R5: a decoded action only ever accompanies an accepted call
  always_comb begin
    if (act_o != ACT_NONE) begin
      a_r5_act_needs_accept: assert (accept_o);
    end
  end

endmodule

// File: rtl/bdm_bank_regs.sv
module bdm_bank_regs
  import bdm_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  localparam int unsigned NB = BDM_NUM_BANKS,
  localparam int unsigned OUT_W = NB * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  bdm_act_e          act_i,
  input  logic [BANK_W-1:0] payload_i,
  output logic [OUT_W-1:0]  data_o
);

  localparam int unsigned LO = 0;
  localparam int unsigned HI = 1;

  logic [NB-1:0][BANK_W-1:0] bank_q, bank_nxt;
  logic [BANK_W-1:0]         shadow_q, shadow_nxt;
  logic                      bank_en, shadow_en;

  // next-state
  always_comb begin
    bank_nxt   = bank_q;
    shadow_nxt = shadow_q;
    bank_en    = 1'b0;
    shadow_en  = 1'b0;
    if (clear_i) begin
      bank_nxt   = '0;
      shadow_nxt = '0;
      bank_en    = 1'b1;
      shadow_en  = 1'b1;
    end else begin
      unique case (act_i)
        ACT_LOW: begin
          bank_nxt[LO] = payload_i;
          bank_en      = 1'b1;
        end
        ACT_HIGH: begin
          bank_nxt[HI] = payload_i;
          bank_en      = 1'b1;
        end
        ACT_STAGE: begin
          shadow_nxt = payload_i;
          shadow_en  = 1'b1;
        end
        ACT_COMMIT: begin
          bank_nxt[HI] = payload_i;
          bank_nxt[LO] = shadow_q;
          bank_en      = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (bank_en) begin
      bank_q <= bank_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (shadow_en) begin
      shadow_q <= shadow_nxt;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_out
    assign data_o[g*BANK_W +: BANK_W] = bank_q[g];
  end

  // R6: disable empties both banks and the shadow
  a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (bank_q == '0) && (shadow_q == '0));

  // R3: staging leaves every output untouched
  a_r3_stage_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && act_i == ACT_STAGE) |=> $stable(bank_q));

  // R5: no action, no change anywhere
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && act_i == ACT_NONE) |=> $stable(bank_q) && $stable(shadow_q));

  // R4: commit moves the prior shadow into the low bank
  a_r4_commit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && act_i == ACT_COMMIT) |=> bank_q[LO] == $past(shadow_q));

  // R1: a direct high write keeps the low bank
  a_r1_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && act_i == ACT_HIGH) |=> $stable(bank_q[LO]));

  // R2: a direct low write keeps the high bank
  a_r2_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && act_i == ACT_LOW) |=> $stable(bank_q[HI]));

endmodule

// File: rtl/bdm_sel_monitor.sv
module bdm_sel_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic accept_i,
  input  logic sel_i,
  output logic pulse_o
);

  logic have_prev_q, have_prev_nxt;
  logic last_sel_q, last_sel_nxt;
  logic pulse_q, pulse_nxt;

  always_comb begin
    have_prev_nxt = have_prev_q;
    last_sel_nxt  = last_sel_q;
    pulse_nxt     = 1'b0;
    if (clear_i) begin
      have_prev_nxt = 1'b0;
      last_sel_nxt  = 1'b0;
    end else if (accept_i) begin
      pulse_nxt     = have_prev_q && (sel_i != last_sel_q);
      have_prev_nxt = 1'b1;
      last_sel_nxt  = sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      last_sel_q  <= 1'b0;
      pulse_q     <= 1'b0;
    end else begin
      have_prev_q <= have_prev_nxt;
      last_sel_q  <= last_sel_nxt;
      pulse_q     <= pulse_nxt;
    end
  end

  assign pulse_o = pulse_q;

  // R7: a pulse comes only from an accepted call that had a predecessor
  a_r7_pulse_origin: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(accept_i) && $past(have_prev_q) && !$past(clear_i));

  // R7: the pulse never lasts two cycles without a fresh call
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !accept_i) |=> !pulse_q);

endmodule

// File: rtl/bank_demux.sv
module bank_demux
  import bdm_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  localparam int unsigned CALL_W = BANK_W + 2,
  localparam int unsigned OUT_W = BDM_NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disable_i,
  input  logic              call_valid_i,
  input  logic [CALL_W-1:0] call_bits_i,
  input  logic              paired_i,
  input  logic              slave_id_i,
  output logic [OUT_W-1:0]  data_o,
  output logic              sel_toggle_o
);

  bdm_act_e          act;
  logic [BANK_W-1:0] payload;
  logic              sel;
  logic              accept;

  bdm_call_decode #(.BANK_W(BANK_W)) u_decode (
    .call_valid_i (call_valid_i),
    .call_bits_i  (call_bits_i),
    .paired_i     (paired_i),
    .slave_id_i   (slave_id_i),
    .clear_i      (disable_i),
    .act_o        (act),
    .payload_o    (payload),
    .sel_o        (sel),
    .accept_o     (accept)
  );

  bdm_bank_regs #(.BANK_W(BANK_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (disable_i),
    .act_i     (act),
    .payload_i (payload),
    .data_o    (data_o)
  );

  bdm_sel_monitor u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (disable_i),
    .accept_i (accept),
    .sel_i    (sel),
    .pulse_o  (sel_toggle_o)
  );

  // R5: an identity mismatch never moves the outputs
  a_r5_foreign_call: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid_i && !disable_i && call_bits_i[CALL_W-1] != slave_id_i)
      |=> $stable(data_o));

endmodule

// File: tb/bank_demux_bench.sv
module bank_demux_bench;

  logic       clk;
  logic       rst_n;
  logic       dis;
  logic       vld;
  logic [3:0] bits;
  logic       paired;
  logic       sid;
  logic [3:0] data;
  logic       tog;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state, built from the requirements
  logic [3:0] exp_d;
  logic [1:0] exp_sh;
  logic       have_prev;
  logic       prev_sel;

  bank_demux u_bank_demux (
    .clk          (clk),
    .rst_n        (rst_n),
    .disable_i    (dis),
    .call_valid_i (vld),
    .call_bits_i  (bits),
    .paired_i     (paired),
    .slave_id_i   (sid),
    .data_o       (data),
    .sel_toggle_o (tog)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one call: drive at negedge, sample at the next negedge
  task automatic do_call(input logic v, input logic idb, input logic s,
                         input logic [1:0] pay, input logic pm, input string req);
    logic acc;
    logic ep;
    acc = v && (idb == sid);
    ep  = 1'b0;
    if (acc) begin
      ep = have_prev && (s != prev_sel);
      have_prev = 1'b1;
      prev_sel  = s;
      case ({pm, s})
        2'b00: exp_d[3:2] = pay;
        2'b01: exp_d[1:0] = pay;
        2'b11: exp_sh = pay;
        default: begin exp_d[3:2] = pay; exp_d[1:0] = exp_sh; end
      endcase
    end
    vld    = v;
    bits   = {idb, s, pay};
    paired = pm;
    @(negedge clk);
    vld = 1'b0;
    chk(req, data, exp_d);
    chk("R7", {3'b0, tog}, {3'b0, ep});
  endtask

  task automatic do_disable(input logic with_call);
    dis  = 1'b1;
    vld  = with_call;
    bits = {sid, 1'b0, 2'b11};
    exp_d = '0; exp_sh = '0; have_prev = 1'b0; prev_sel = 1'b0;
    @(negedge clk);
    dis = 1'b0;
    vld = 1'b0;
    chk("R6", data, 4'h0);
    chk("R7", {3'b0, tog}, 4'h0);
  endtask

  task automatic t_reset;
    chk("R6", data, 4'h0);
    chk("R7", {3'b0, tog}, 4'h0);
  endtask

  task automatic t_direct;
    do_call(1, sid, 0, 2'b10, 0, "R1");
    do_call(1, sid, 1, 2'b01, 0, "R2");
    do_call(1, sid, 0, 2'b01, 0, "R1");
    do_call(1, sid, 1, 2'b11, 0, "R2");
    do_call(1, sid, 1, 2'b10, 0, "R2");
    do_call(1, sid, 0, 2'b11, 0, "R1");
  endtask

  task automatic t_paired;
    do_call(1, sid, 1, 2'b01, 1, "R3");
    do_call(1, sid, 1, 2'b10, 1, "R8");
    do_call(1, sid, 0, 2'b00, 1, "R4");
    do_call(1, sid, 0, 2'b01, 1, "R8");
    do_call(1, sid, 1, 2'b11, 1, "R3");
    do_call(1, sid, 0, 2'b10, 1, "R4");
  endtask

  task automatic t_mismatch;
    do_call(1, ~sid, 1, 2'b00, 1, "R5");
    do_call(0, sid, 1, 2'b01, 1, "R5");
    do_call(1, ~sid, 0, 2'b01, 0, "R5");
    do_call(0, sid, 1, 2'b00, 0, "R5");
    // shadow must still hold its earlier value
    do_call(1, sid, 0, 2'b00, 1, "R5");
    sid = 1'b0;
    do_call(1, 1'b1, 1, 2'b01, 0, "R5");
    do_call(1, 1'b0, 1, 2'b01, 0, "R5");
    sid = 1'b1;
  endtask

  task automatic t_disable;
    do_call(1, sid, 1, 2'b11, 1, "R3");
    do_disable(1'b1);
    // shadow was cleared: commit brings zeros into the low bank
    do_call(1, sid, 0, 2'b10, 1, "R6");
  endtask

  task automatic t_toggle;
    do_disable(1'b0);
    do_call(1, sid, 1, 2'b01, 0, "R7");
    do_call(1, sid, 1, 2'b10, 0, "R7");
    do_call(1, sid, 0, 2'b10, 0, "R7");
    @(negedge clk);
    chk("R7", {3'b0, tog}, 4'h0);
    do_call(1, ~sid, 1, 2'b00, 0, "R7");
    do_call(1, sid, 1, 2'b00, 1, "R7");
    do_call(1, sid, 0, 2'b11, 1, "R7");
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dis = 1'b0; vld = 1'b0; bits = '0; paired = 1'b0; sid = 1'b1;
    exp_d = '0; exp_sh = '0; have_prev = 1'b0; prev_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_paired();
    t_mismatch();
    t_disable();
    t_toggle();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule